// File: doc/BRIEF.md
# Floating-Point Status Word Unit

This block keeps the 32-bit status word that sits beside a single-precision arithmetic core. When an operation completes, the core reports its raw exception indications: invalid, divide-by-zero, overflow, underflow and inexact, plus input-denormal and output-denormal. The unit then rebuilds the per-operation cause bits and merges the sticky flag bits for exceptions whose trap is masked. It recomputes the summary flag and raises a trap request when any cause that has its enable set occurs. It also latches zero and sign condition flags from the operation's 32-bit result.

Software may write the word at any time. The write can clear cause bits but never set them, and the remaining fields take the written value. The two low bits select the rounding mode and are driven straight back to the arithmetic core.

Top module: `fpsr_unit`

Status word layout: rounding mode [1:0]; cause bits [7:2] with invalid=2, overflow=3, divide-by-zero=4, underflow=5, inexact=6, unimplemented=7; denormal-flush control [8]; enables [14:10] with invalid=10, overflow=11, divide-by-zero=12, underflow=13, inexact=14; sticky flags [30:26] with invalid=26, overflow=27, divide-by-zero=28, underflow=29, inexact=30; summary [31]. The same exception order is used on `exc_i`: bit0 invalid, bit1 overflow, bit2 divide-by-zero, bit3 underflow, bit4 inexact.

## Requirements
- R1: After reset, `status_o`, `trap_o`, `zero_o` and `sign_o` are all zero, and `rnd_mode_o` is 0.
- R2: On an operation update (`op_valid_i`), all six cause bits [7:2] are first cleared. Each exception reported on `exc_i` then sets its cause bit (exc_i[k] sets bit 2+k).
- R3: On an operation update, an exception's sticky flag (bit 26+k) is set only when its enable bit (10+k) is 0. Flags already set are never cleared by an operation.
- R4: When `in_denorm_i` or `out_denorm_i` is reported and bit 8 is 0, cause bit 7 is set. When bit 8 is 1, cause bit 7 is not set. Bit 7 has no sticky flag.
- R5: Bit 31 of `status_o` equals the OR of the five sticky flag bits [30:26] after every update.
- R6: `trap_o` is a one-cycle pulse on the clock edge that follows an `op_valid_i` cycle. It is raised when the new cause bits [6:2] ANDed with the enables [14:10] are nonzero, or when cause bit 7 is set, since bit 7 is always enabled. `trap_code_o` reads 21 whenever `trap_o` is high.
- R7: A software write (`wr_en_i`) produces (old | 0x7FFFFF03) & (wr_data_i with bit 31 cleared). Bit 31 is then recomputed as in R5. Cause bits can only be cleared by the write. Bits [1:0] and [30:8] take the written value.
- R8: `rnd_mode_o` always equals status bits [1:0]. The encoding is 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R9: On an operation update, `zero_o` becomes 1 exactly when `result_i[30:0]` is zero, and `sign_o` becomes `result_i[31]`. Both hold their value in other cycles.
- R10: When a write and an operation occur in the same cycle, the write is applied first and the operation update is applied on top of the written word, including its enables and flush control.
- R11: In a cycle with neither a write nor an operation, the status word is unchanged and `trap_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation completed this cycle |
| exc_i | input | 5 | Exception indications: invalid, overflow, div-by-zero, underflow, inexact (bit0..bit4) |
| in_denorm_i | input | 1 | Denormal operand seen |
| out_denorm_i | input | 1 | Denormal result produced |
| result_i | input | 32 | Operation result for condition flags |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write value |
| status_o | output | 32 | Status word |
| rnd_mode_o | output | 2 | Rounding mode to arithmetic core |
| trap_o | output | 1 | Trap request pulse |
| trap_code_o | output | 5 | Trap exception number |
| zero_o | output | 1 | Zero condition flag |
| sign_o | output | 1 | Sign condition flag |

## Verification
Some rules are checked by assertions on every cycle. These are the summary/flag agreement, the rounding-mode mirror, the one-cycle trap pulse and its code, the stability of the word when idle, the rule that operations never clear sticky flags, and the rule that writes never raise cause bits. The bench scenarios are needed to show the exact cause and flag patterns for given exceptions and enables. They also cover the flush-controlled suppression of the unimplemented cause, the ordering of a write that coincides with an operation, and the condition flags taken from particular results.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NUM_EXC = 5;
  localparam int unsigned RM_LSB  = 0;
  localparam int unsigned CAU_LSB = 2;
  localparam int unsigned UNI_BIT = CAU_LSB + NUM_EXC;
  localparam int unsigned DN_BIT  = 8;
  localparam int unsigned EN_LSB  = 10;
  localparam int unsigned FLG_LSB = 26;
  localparam int unsigned SUM_BIT = 31;
  localparam logic [WORD_W-1:0] WR_KEEP_MASK = 32'h7FFF_FF03;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_ZERO      = 2'd1,
    RND_POS_INF   = 2'd2,
    RND_NEG_INF   = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/fpsr_write_merge.sv
module fpsr_write_merge
  import fpsr_pkg::*;
(
  input  logic [WORD_W-1:0] old_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] merged;

  always_comb begin
    merged = (old_i | WR_KEEP_MASK) & {1'b0, wr_data_i[WORD_W-2:0]};
    merged[SUM_BIT] = |merged[FLG_LSB +: NUM_EXC];
    word_o = wr_en_i ? merged : old_i;
  end
endmodule

// File: rtl/fpsr_op_update.sv
module fpsr_op_update
  import fpsr_pkg::*;
(
  input  logic [WORD_W-1:0]  base_i,
  input  logic               op_valid_i,
  input  logic [NUM_EXC-1:0] exc_i,
  input  logic               in_denorm_i,
  input  logic               out_denorm_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               trap_o
);
  logic [NUM_EXC-1:0] en;
  logic [NUM_EXC-1:0] flg_set;
  logic               uni;
  logic [WORD_W-1:0]  upd;

  assign en  = base_i[EN_LSB +: NUM_EXC];
  assign uni = (in_denorm_i | out_denorm_i) & ~base_i[DN_BIT];

  for (genvar k = 0; k < NUM_EXC; k++) begin : g_flag
    assign flg_set[k] = exc_i[k] & ~en[k];
  end

  always_comb begin
    upd = base_i;
    upd[CAU_LSB +: NUM_EXC] = exc_i;
    upd[UNI_BIT] = uni;
    upd[FLG_LSB +: NUM_EXC] = base_i[FLG_LSB +: NUM_EXC] | flg_set;
    upd[SUM_BIT] = |upd[FLG_LSB +: NUM_EXC];
    word_o = op_valid_i ? upd : base_i;
    trap_o = op_valid_i & ((|(exc_i & en)) | uni);
  end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
#(
  parameter int unsigned TRAP_CODE   = 21,
  parameter int unsigned TRAP_CODE_W = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   op_valid_i,
  input  logic [NUM_EXC-1:0]     exc_i,
  input  logic                   in_denorm_i,
  input  logic                   out_denorm_i,
  input  logic [WORD_W-1:0]      result_i,
  input  logic                   wr_en_i,
  input  logic [WORD_W-1:0]      wr_data_i,
  output logic [WORD_W-1:0]      status_o,
  output logic [1:0]             rnd_mode_o,
  output logic                   trap_o,
  output logic [TRAP_CODE_W-1:0] trap_code_o,
  output logic                   zero_o,
  output logic                   sign_o
);
  logic [WORD_W-1:0] status_q, after_wr, after_op;
  logic              trap_d, trap_q, zero_q, sign_q;

  fpsr_write_merge u_wr (
    .old_i     (status_q),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .word_o    (after_wr)
  );

  fpsr_op_update u_op (
    .base_i       (after_wr),
    .op_valid_i   (op_valid_i),
    .exc_i        (exc_i),
    .in_denorm_i  (in_denorm_i),
    .out_denorm_i (out_denorm_i),
    .word_o       (after_op),
    .trap_o       (trap_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      trap_q   <= 1'b0;
      zero_q   <= 1'b0;
      sign_q   <= 1'b0;
    end else begin
      status_q <= after_op;
      trap_q   <= trap_d;
      if (op_valid_i) begin
        zero_q <= ~|result_i[WORD_W-2:0];
        sign_q <= result_i[WORD_W-1];
      end
    end
  end

  assign status_o    = status_q;
  assign rnd_mode_o  = status_q[RM_LSB +: 2];
  assign trap_o      = trap_q;
  assign trap_code_o = trap_q ? TRAP_CODE_W'(TRAP_CODE) : '0;
  assign zero_o      = zero_q;
  assign sign_o      = sign_q;

  p_summary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[SUM_BIT] == (|status_o[FLG_LSB +: NUM_EXC]));

  p_rnd_mirror_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_mode_o == status_o[1:0]);

  p_trap_after_op_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !trap_o);

  p_trap_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> trap_code_o == TRAP_CODE_W'(TRAP_CODE));

  p_idle_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !wr_en_i) |=> $stable(status_o));

  p_flags_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !wr_en_i) |=>
      ((status_o[FLG_LSB +: NUM_EXC] & $past(status_o[FLG_LSB +: NUM_EXC]))
        == $past(status_o[FLG_LSB +: NUM_EXC])));

  p_wr_cause_clear_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !op_valid_i) |=>
      ((status_o[CAU_LSB +: 6] & ~$past(status_o[CAU_LSB +: 6])) == 6'd0));

  p_flush_no_unimpl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !wr_en_i && status_o[DN_BIT]) |=> !status_o[UNI_BIT]);
endmodule

// File: tb/fpsr_unit_tb_top.sv
module fpsr_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [4:0]  exc_i = '0;
  logic        in_denorm_i = 1'b0;
  logic        out_denorm_i = 1'b0;
  logic [31:0] result_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] status_o;
  logic [1:0]  rnd_mode_o;
  logic        trap_o;
  logic [4:0]  trap_code_o;
  logic        zero_o;
  logic        sign_o;

  always #2 clk_i = ~clk_i;

  fpsr_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .exc_i(exc_i),
    .in_denorm_i(in_denorm_i), .out_denorm_i(out_denorm_i), .result_i(result_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .status_o(status_o),
    .rnd_mode_o(rnd_mode_o), .trap_o(trap_o), .trap_code_o(trap_code_o),
    .zero_o(zero_o), .sign_o(sign_o)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_status;
  logic        m_trap, m_zero, m_sign;

  // {wr, wdata[31:0], op, exc[4:0], in_dn, out_dn, result[31:0]}
  localparam int NV = 14;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 32'h0000_0001, 1'b0, 5'b00000, 1'b0, 1'b0, 32'h0000_0000},
    {1'b0, 32'h0,         1'b1, 5'b00001, 1'b0, 1'b0, 32'h0000_0000},
    {1'b0, 32'h0,         1'b1, 5'b10000, 1'b0, 1'b0, 32'h8000_0000},
    {1'b1, 32'h0000_7C02, 1'b0, 5'b00000, 1'b0, 1'b0, 32'h0000_0000},
    {1'b0, 32'h0,         1'b1, 5'b00010, 1'b0, 1'b0, 32'h4000_0000},
    {1'b0, 32'h0,         1'b1, 5'b00000, 1'b1, 1'b0, 32'h0000_0001},
    {1'b1, 32'h0000_0103, 1'b0, 5'b00000, 1'b0, 1'b0, 32'h0000_0000},
    {1'b0, 32'h0,         1'b1, 5'b00000, 1'b0, 1'b1, 32'h8000_0001},
    {1'b0, 32'h0,         1'b1, 5'b01100, 1'b0, 1'b0, 32'h3F80_0000},
    {1'b0, 32'h0,         1'b0, 5'b00000, 1'b0, 1'b0, 32'hFFFF_FFFF},
    {1'b1, 32'hFFFF_FFFF, 1'b0, 5'b00000, 1'b0, 1'b0, 32'h0000_0000},
    {1'b1, 32'h0000_0003, 1'b1, 5'b01000, 1'b0, 1'b0, 32'h0000_0000},
    {1'b1, 32'h0000_0400, 1'b1, 5'b00001, 1'b1, 1'b0, 32'h7FFF_FFFF},
    {1'b0, 32'h0,         1'b1, 5'b11111, 1'b0, 1'b1, 32'h8000_0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic model_step(input bit wr, input logic [31:0] wd, input bit op,
                            input logic [4:0] ex, input bit idn, input bit odn,
                            input logic [31:0] res);
    logic [31:0] w;
    w = m_status;
    m_trap = 1'b0;
    if (wr) begin
      for (int b = 0; b < 31; b++)
        if (b >= 2 && b <= 7) w[b] = m_status[b] & wd[b];
        else w[b] = wd[b];
      w[31] = |w[30:26];
    end
    if (op) begin
      for (int k = 0; k < 5; k++) begin
        w[2+k] = ex[k];
        if (ex[k] && !w[10+k]) w[26+k] = 1'b1;
        if (ex[k] && w[10+k]) m_trap = 1'b1;
      end
      w[7] = (idn || odn) && !w[8];
      if (w[7]) m_trap = 1'b1;
      w[31] = |w[30:26];
      m_zero = (res[30:0] == 31'd0);
      m_sign = res[31];
    end
    m_status = w;
  endtask

  task automatic check_outputs(input string tag);
    chk(status_o == m_status, {tag, " R2/R3/R4/R5/R7 status"}, status_o, m_status);
    chk(trap_o == m_trap, {tag, " R6 trap"}, {31'd0, trap_o}, {31'd0, m_trap});
    if (m_trap) chk(trap_code_o == 5'd21, {tag, " R6 code"}, {27'd0, trap_code_o}, 32'd21);
    chk(rnd_mode_o == m_status[1:0], {tag, " R8 rnd"}, {30'd0, rnd_mode_o}, {30'd0, m_status[1:0]});
    chk(zero_o == m_zero && sign_o == m_sign, {tag, " R9 cond"},
        {30'd0, zero_o, sign_o}, {30'd0, m_zero, m_sign});
  endtask

  task automatic apply(input logic [72:0] v);
    @(negedge clk_i);
    wr_en_i = v[72]; wr_data_i = v[71:40]; op_valid_i = v[39];
    exc_i = v[38:34]; in_denorm_i = v[33]; out_denorm_i = v[32]; result_i = v[31:0];
    model_step(v[72], v[71:40], v[39], v[38:34], v[33], v[32], v[31:0]);
    @(negedge clk_i);
    wr_en_i = 1'b0; op_valid_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    m_status = '0; m_trap = 0; m_zero = 0; m_sign = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(status_o == 32'd0 && trap_o == 0 && zero_o == 0 && sign_o == 0 && rnd_mode_o == 0,
        "R1 reset", status_o, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check_outputs($sformatf("vec%0d", i));
      // R11: trap pulse gone and word unchanged in the idle cycle after
      m_trap = 1'b0;
      @(negedge clk_i);
      chk(trap_o == 1'b0, "R6/R11 pulse width", {31'd0, trap_o}, 32'd0);
      chk(status_o == m_status, "R11 idle stable", status_o, m_status);
    end

    // R10 directed: write enables and flush on same cycle as overflow + denormal
    apply({1'b1, 32'h0000_0900, 1'b1, 5'b00010, 1'b1, 1'b1, 32'h0000_0000});
    check_outputs("R10 write+op");
    chk(trap_o == 1'b1 && status_o[7] == 1'b0 && status_o[27] == 1'b0,
        "R10 enables/flush from write", status_o, m_status);

    // R1 reset mid-run clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(status_o == 32'd0 && trap_o == 0 && zero_o == 0 && sign_o == 0,
        "R1 async reset", status_o, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule